// File: doc/BRIEF.md
# Adaptive Noise-Cancellation Combiner for a Two-Stage Cascaded Modulator

This block merges the digital codes of the two stages of a cascaded noise-shaping modulator into one output word. The first-stage code passes through a fixed two-cycle delay. The second-stage code is delayed once and sent through a second-order difference filter (1 − z⁻¹)². The filter output is then scaled by a gain k and subtracted from the delayed first-stage code. The result is a 16-bit signed word with 9 fractional bits. It is rounded and then clipped to the 16-bit range.

When the gain k does not match the analog stages, first-stage quantization noise leaks into the output. A square-wave stimulus injected by the analog side shows up in the output as a short spike after every edge of the stimulus. The block watches its copy of the stimulus level. A short three-valued window follows each edge: +1 after a rising edge, −1 after a falling edge and 0 elsewhere. Inside this window the output is correlated and accumulated. When the accumulator crosses a threshold it resets to zero and moves a signed control code n by one step. The gain is k = K_BASE + n·K_STEP, an unsigned Q2.10 value. During reset, n is loaded from an input port, so adaptation starts from a gain estimated beforehand. Adaptation is active only while the calibration-enable input is high, which is the time the stimulus is injected.

Top module: `mash_noise_combiner`

## Requirements
- R1: While rst_n is low, y_out is 0 and n_code equals n_init, so k_gain equals 1024 + 8·n_init.
- R2: k_gain always equals 1024 + 8·n_code, an unsigned Q2.10 value where 1024 stands for 1.0.
- R3: After clock edge e, y_out = floor((1024·a − k·f + 1) / 2). Here a is s1_code sampled at edge e−2, f = b1 − 2·b2 + b3, where bj is s2_code sampled at edge e−j, and k is the k_gain value present before edge e.
- R4: When the rounded value of R3 lies outside −32768…32767, y_out takes the nearest limit.
- R5: A change of stim_in sampled at edge e opens a window. The correlation sign is +1 for a rising change and −1 for a falling change. It applies at edges e+3 through e+6 and is 0 outside the window. A new change restarts the window.
- R6: At each edge with cal_en high, a = acc + sign·y_out is formed. If a ≥ 4096, acc becomes 0 and n_code rises by 1. If a ≤ −4096, acc becomes 0 and n_code falls by 1. Otherwise acc becomes a. The accumulator starts at 0 after reset.
- R7: n_code saturates at 127 and −128. A step beyond either limit leaves it unchanged.
- R8: At an edge with cal_en low, acc is cleared and n_code holds, whatever stim_in and y_out are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s1_code | input | 4 | First-stage code, signed |
| s2_code | input | 4 | Second-stage code, signed |
| stim_in | input | 1 | Level of the injected square-wave stimulus |
| cal_en | input | 1 | Enables adaptation while the stimulus is injected |
| n_init | input | 8 | Signed start value for n, loaded during reset |
| y_out | output | 16 | Combined output, signed, 9 fractional bits |
| n_code | output | 8 | Signed gain control code n |
| k_gain | output | 12 | Current gain k, unsigned Q2.10 |

## Verification
The output word depends on the first-stage code from two edges earlier and on second-stage codes from one, two and three edges earlier. A change of n shows up in k_gain at once and affects y_out from the following edge. A stimulus change opens its correlation window three edges later, so with a steady output the first move of n comes six edges after the change. The bench keeps a reference model that advances on each rising edge with the inputs held since the previous falling edge. It compares y_out, n_code and k_gain at every falling edge. The directed checks count edges from the stimulus change to reach the exact cycle in which n is due to move.

// File: rtl/mash_comb_pkg.sv
// Shared types for the noise-cancellation combiner.
// Assumes: the correlation sign is a two-bit signed value limited to -1, 0 and +1.
package mash_comb_pkg;
    typedef logic signed [1:0] corr_sign_t;
    localparam corr_sign_t SIGN_POS  = 2'sb01;
    localparam corr_sign_t SIGN_NEG  = 2'sb11;
    localparam corr_sign_t SIGN_ZERO = 2'sb00;
endpackage

// File: rtl/mash_comb_datapath.sv
// Combines the two stage codes: a delayed first-stage code minus k times the
// second difference of the delayed second-stage code. Rounds half up and clips.
// Assumes: K_FRAC >= OUT_FRAC and k is unsigned with K_FRAC fractional bits.
module mash_comb_datapath #(
    parameter int S1_W     = 4,
    parameter int S2_W     = 4,
    parameter int K_W      = 12,
    parameter int K_FRAC   = 10,
    parameter int OUT_W    = 16,
    parameter int OUT_FRAC = 9,
    parameter int S1_DLY   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [S1_W-1:0]  s1_code,
    input  logic signed [S2_W-1:0]  s2_code,
    input  logic        [K_W-1:0]   k_gain,
    output logic signed [OUT_W-1:0] y_q
);
    localparam int DROP   = K_FRAC - OUT_FRAC;
    localparam int F_W    = S2_W + 3;
    localparam int FULL_W = K_W + F_W + S1_W + 4;
    localparam logic signed [FULL_W-1:0] Y_MAX = FULL_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [FULL_W-1:0] Y_MIN = -FULL_W'(64'sd1 <<< (OUT_W - 1));

    logic signed [S1_W-1:0]   s1_pipe [S1_DLY];
    logic signed [S2_W-1:0]   s2_hist [3];
    logic signed [F_W-1:0]    diff2;
    logic signed [FULL_W-1:0] prod, full, rnd;

    // Shift the first-stage delay line and the second-stage history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < S1_DLY; i++) s1_pipe[i] <= '0;
            for (int j = 0; j < 3; j++)      s2_hist[j] <= '0;
        end else begin
            s1_pipe[0] <= s1_code;
            for (int i = 1; i < S1_DLY; i++) s1_pipe[i] <= s1_pipe[i-1];
            s2_hist[0] <= s2_code;
            s2_hist[1] <= s2_hist[0];
            s2_hist[2] <= s2_hist[1];
        end
    end

    // Second difference of the delayed second-stage code, then scaling and subtraction.
    always_comb begin
        diff2 = F_W'(s2_hist[0]) - (F_W'(s2_hist[1]) <<< 1) + F_W'(s2_hist[2]);
        prod  = FULL_W'($signed({1'b0, k_gain})) * FULL_W'(diff2);
        full  = (FULL_W'(s1_pipe[S1_DLY-1]) <<< K_FRAC) - prod;
    end

    // Rounding step: only present when fractional bits are dropped.
    generate
        if (DROP > 0) begin : g_round
            localparam logic signed [FULL_W-1:0] HALF = FULL_W'(64'sd1 <<< (DROP - 1));
            assign rnd = (full + HALF) >>> DROP;
        end else begin : g_exact
            assign rnd = full;
        end
    endgenerate

    // Register the clipped output word.
    always_ff @(posedge clk) begin
        if (!rst_n)           y_q <= '0;
        else if (rnd > Y_MAX) y_q <= Y_MAX[OUT_W-1:0];
        else if (rnd < Y_MIN) y_q <= Y_MIN[OUT_W-1:0];
        else                  y_q <= rnd[OUT_W-1:0];
    end
endmodule

// File: rtl/mash_comb_mask.sv
// Builds the three-valued correlation window from the stimulus level.
// Each change opens a window that is nonzero from MASK_DLY to
// MASK_DLY+MASK_LEN-1 counts after the change. A later change restarts it.
// Assumes: MASK_DLY >= 1 and MASK_LEN >= 1.
module mash_comb_mask
    import mash_comb_pkg::*;
#(
    parameter int MASK_DLY = 2,
    parameter int MASK_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stim_in,
    output corr_sign_t mask,
    output logic       stim_last
);
    localparam int LAST  = MASK_DLY + MASK_LEN - 1;
    localparam int CNT_W = $clog2(LAST + 2);
    localparam logic [CNT_W-1:0] C_DLY  = CNT_W'(MASK_DLY);
    localparam logic [CNT_W-1:0] C_LAST = CNT_W'(LAST);

    logic             running;
    logic [CNT_W-1:0] cnt;
    corr_sign_t       sgn;

    // Detect stimulus changes and step the window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stim_last <= 1'b0;
            running   <= 1'b0;
            cnt       <= '0;
            sgn       <= SIGN_ZERO;
        end else begin
            stim_last <= stim_in;
            if (stim_in != stim_last) begin
                running <= 1'b1;
                cnt     <= '0;
                sgn     <= stim_in ? SIGN_POS : SIGN_NEG;
            end else if (running) begin
                if (cnt == C_LAST) running <= 1'b0;
                else               cnt     <= cnt + 1'b1;
            end
        end
    end

    // Select the window sign while the counter is inside the active span.
    always_comb mask = (running && cnt >= C_DLY) ? sgn : SIGN_ZERO;
endmodule

// File: rtl/mash_comb_adapt.sv
// Accumulates the output multiplied by the window sign. When the sum crosses
// the threshold it clears and steps the saturating code n. Produces k from n.
// Assumes: K_BASE and K_STEP keep k within 0 .. 2**K_W-1 over the whole range of n.
module mash_comb_adapt
    import mash_comb_pkg::*;
#(
    parameter int OUT_W  = 16,
    parameter int ACC_W  = 24,
    parameter int THRESH = 4096,
    parameter int N_W    = 8,
    parameter int K_W    = 12,
    parameter int K_BASE = 1024,
    parameter int K_STEP = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cal_en,
    input  corr_sign_t              mask,
    input  logic signed [OUT_W-1:0] y_q,
    input  logic signed [N_W-1:0]   n_init,
    output logic signed [N_W-1:0]   n_code,
    output logic        [K_W-1:0]   k_gain,
    output logic                    adj_up,
    output logic                    adj_dn
);
    localparam int KX_W = K_W + N_W + 2;
    localparam logic signed [ACC_W-1:0] T_POS = ACC_W'(THRESH);
    localparam logic signed [ACC_W-1:0] T_NEG = -ACC_W'(THRESH);
    localparam logic signed [N_W-1:0]   N_MAX = {1'b0, {(N_W-1){1'b1}}};
    localparam logic signed [N_W-1:0]   N_MIN = {1'b1, {(N_W-1){1'b0}}};

    logic signed [ACC_W-1:0] acc, corr, acc_nx;
    logic signed [KX_W-1:0]  k_wide;

    // Correlate the output with the window sign and detect threshold crossings.
    always_comb begin
        if (mask == SIGN_POS)      corr = ACC_W'(y_q);
        else if (mask == SIGN_NEG) corr = -ACC_W'(y_q);
        else                       corr = '0;
        acc_nx = acc + corr;
        adj_up = cal_en && (acc_nx >= T_POS);
        adj_dn = cal_en && (acc_nx <= T_NEG);
    end

    // Accumulate and reset; clear while adaptation is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !cal_en)    acc <= '0;
        else if (adj_up || adj_dn) acc <= '0;
        else                       acc <= acc_nx;
    end

    // Step the control code by one, held at its signed limits.
    always_ff @(posedge clk) begin
        if (!rst_n)                        n_code <= n_init;
        else if (adj_up && n_code != N_MAX) n_code <= n_code + 1'b1;
        else if (adj_dn && n_code != N_MIN) n_code <= n_code - 1'b1;
    end

    // Map the code onto the gain.
    always_comb begin
        k_wide = KX_W'(K_BASE) + KX_W'(n_code) * KX_W'(K_STEP);
        k_gain = k_wide[K_W-1:0];
    end
endmodule

// File: rtl/mash_noise_combiner.sv
// Top of the adaptive noise-cancellation combiner: output datapath,
// stimulus window generator and gain adaptation.
// Assumes: stim_in and cal_en are synchronous to clk.
module mash_noise_combiner
    import mash_comb_pkg::*;
#(
    parameter int S1_W     = 4,
    parameter int S2_W     = 4,
    parameter int K_W      = 12,
    parameter int K_FRAC   = 10,
    parameter int OUT_W    = 16,
    parameter int OUT_FRAC = 9,
    parameter int N_W      = 8,
    parameter int K_BASE   = 1024,
    parameter int K_STEP   = 8,
    parameter int ACC_W    = 24,
    parameter int THRESH   = 4096,
    parameter int MASK_DLY = 2,
    parameter int MASK_LEN = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [S1_W-1:0]  s1_code,
    input  logic signed [S2_W-1:0]  s2_code,
    input  logic                    stim_in,
    input  logic                    cal_en,
    input  logic signed [N_W-1:0]   n_init,
    output logic signed [OUT_W-1:0] y_out,
    output logic signed [N_W-1:0]   n_code,
    output logic        [K_W-1:0]   k_gain
);
    corr_sign_t mask_val;
    logic       stim_last;
    logic       adj_up, adj_dn;

    mash_comb_datapath #(
        .S1_W(S1_W), .S2_W(S2_W), .K_W(K_W), .K_FRAC(K_FRAC),
        .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC), .S1_DLY(2)
    ) u_dp (
        .clk(clk), .rst_n(rst_n), .s1_code(s1_code), .s2_code(s2_code),
        .k_gain(k_gain), .y_q(y_out)
    );

    mash_comb_mask #(.MASK_DLY(MASK_DLY), .MASK_LEN(MASK_LEN)) u_mask (
        .clk(clk), .rst_n(rst_n), .stim_in(stim_in),
        .mask(mask_val), .stim_last(stim_last)
    );

    mash_comb_adapt #(
        .OUT_W(OUT_W), .ACC_W(ACC_W), .THRESH(THRESH), .N_W(N_W),
        .K_W(K_W), .K_BASE(K_BASE), .K_STEP(K_STEP)
    ) u_adapt (
        .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .mask(mask_val),
        .y_q(y_out), .n_init(n_init), .n_code(n_code), .k_gain(k_gain),
        .adj_up(adj_up), .adj_dn(adj_dn)
    );
endmodule

// File: rtl/mash_comb_checker.sv
// Temporal checks on the combiner, attached to every instance by bind.
// Assumes: n_init is held steady while rst_n rises.
module mash_comb_checker #(
    parameter int N_W   = 8,
    parameter int OUT_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cal_en,
    input logic                    stim_in,
    input logic                    stim_last,
    input logic signed [1:0]       mask,
    input logic                    adj_up,
    input logic                    adj_dn,
    input logic signed [N_W-1:0]   n_code,
    input logic signed [N_W-1:0]   n_init,
    input logic signed [OUT_W-1:0] y_out
);
    localparam logic signed [N_W-1:0] N_MAX = {1'b0, {(N_W-1){1'b1}}};
    localparam logic signed [N_W-1:0] N_MIN = {1'b1, {(N_W-1){1'b0}}};

    assert_reset_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (n_code == n_init && y_out == '0));

    assert_window_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stim_in != stim_last) |=> (mask == 2'sb00));

    assert_up_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_up && n_code != N_MAX) |=> (n_code == $past(n_code) + 1'b1));

    assert_down_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_dn && n_code != N_MIN) |=> (n_code == $past(n_code) - 1'b1));

    assert_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_up && n_code == N_MAX) |=> (n_code == N_MAX));

    assert_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_dn && n_code == N_MIN) |=> (n_code == N_MIN));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_en |=> $stable(n_code));
endmodule

bind mash_noise_combiner mash_comb_checker #(.N_W(N_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .stim_in(stim_in),
    .stim_last(stim_last), .mask(mask_val), .adj_up(adj_up), .adj_dn(adj_dn),
    .n_code(n_code), .n_init(n_init), .y_out(y_out)
);

// File: tb/mash_noise_combiner_test.sv
// Bench: a behavioural reference model advanced on every rising edge and
// compared with the outputs on every falling edge, plus directed scenarios.
module mash_noise_combiner_test;
    localparam int CLK_P = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic signed [3:0] s1_code = '0;
    logic signed [3:0] s2_code = '0;
    logic              stim_in = 1'b0;
    logic              cal_en = 1'b0;
    logic signed [7:0] n_init = '0;
    logic signed [15:0] y_out;
    logic signed [7:0]  n_code;
    logic [11:0]        k_gain;

    int nchk = 0, nfail = 0;
    int s1q[$], s2q[$];
    int y_m = 0, n_m = 0, acc_m = 0, cnt_m = 0, sgn_m = 0;
    bit run_m = 0, stim_pm = 0, seen_sat = 0;

    mash_noise_combiner uut (
        .clk(clk), .rst_n(rst_n), .s1_code(s1_code), .s2_code(s2_code),
        .stim_in(stim_in), .cal_en(cal_en), .n_init(n_init),
        .y_out(y_out), .n_code(n_code), .k_gain(k_gain)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model: one rising edge with the inputs currently held.
    task automatic model_edge();
        if (!rst_n) begin
            s1q = '{0, 0, 0}; s2q = '{0, 0, 0};
            y_m = 0; n_m = int'(n_init); acc_m = 0;
            run_m = 0; cnt_m = 0; sgn_m = 0; stim_pm = 0;
        end else begin
            int msk, km, f, full, yn, a;
            msk  = (run_m && cnt_m >= 2 && cnt_m <= 5) ? sgn_m : 0;
            km   = 1024 + 8 * n_m;
            f    = s2q[0] - 2 * s2q[1] + s2q[2];
            full = s1q[1] * 1024 - km * f;
            yn   = (full + 1) >>> 1;
            if (yn > 32767) yn = 32767;
            if (yn < -32768) yn = -32768;
            if (cal_en) begin
                a = acc_m + msk * y_m;
                if (a >= 4096)       begin acc_m = 0; if (n_m < 127) n_m++; end
                else if (a <= -4096) begin acc_m = 0; if (n_m > -128) n_m--; end
                else acc_m = a;
            end else acc_m = 0;
            if (stim_in != stim_pm) begin
                run_m = 1; cnt_m = 0; sgn_m = stim_in ? 1 : -1;
            end else if (run_m) begin
                if (cnt_m == 5) run_m = 0; else cnt_m++;
            end
            stim_pm = stim_in;
            s1q.push_front(int'(s1_code)); void'(s1q.pop_back());
            s2q.push_front(int'(s2_code)); void'(s2q.pop_back());
            y_m = yn;
        end
    endtask

    // Advance one clock and compare every output with the model.
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(int'(y_out) == y_m, (y_m == 32767 || y_m == -32768) ? "R4 y_out clip" : "R3 y_out",
            int'(y_out), y_m);
        if (int'(y_out) == -32768) seen_sat = 1;
        chk(int'(n_code) == n_m, "R6 n_code", int'(n_code), n_m);
        chk(int'(k_gain) == 1024 + 8 * n_m, "R2 k_gain", int'(k_gain), 1024 + 8 * n_m);
    endtask

    task automatic do_reset(input int ninit);
        rst_n = 1'b0; cal_en = 1'b0; stim_in = 1'b0; n_init = 8'(ninit);
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_P * 100000);
        nfail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        // R1: reset state with a nonzero start code.
        do_reset(5);
        rst_n = 1'b0;
        tick();
        chk(y_out == 0, "R1 y_out in reset", int'(y_out), 0);
        chk(int'(n_code) == 5, "R1 n_code in reset", int'(n_code), 5);
        chk(int'(k_gain) == 1064, "R1 k_gain in reset", int'(k_gain), 1064);
        rst_n = 1'b1;

        // R3 R5 R6: random codes with a toggling stimulus; model compared every edge.
        cal_en = 1'b1;
        for (int i = 0; i < 600; i++) begin
            s1_code = 4'($urandom_range(15));
            s2_code = 4'($urandom_range(15));
            if (i % 12 == 0) stim_in = ~stim_in;
            if (i % 7 == 3 && i > 100) stim_in = ~stim_in;
            cal_en = !(i >= 300 && i < 360);
            tick();
        end

        // R5 R6: exact threshold hit, six edges after the stimulus rises.
        s1_code = 4'sd2; s2_code = '0;
        do_reset(0);
        repeat (4) tick();
        cal_en = 1'b1; stim_in = 1'b1;
        tick();
        repeat (4) tick();
        tick();
        chk(int'(n_code) == 0, "R5 no step before window total reaches threshold", int'(n_code), 0);
        tick();
        chk(int'(n_code) == 1, "R6 step when total equals threshold", int'(n_code), 1);

        // R8: a falling edge while disabled must not move n.
        cal_en = 1'b0; stim_in = 1'b0;
        repeat (10) tick();
        chk(int'(n_code) == 1, "R8 n held while disabled", int'(n_code), 1);

        // R7: upward saturation.
        s1_code = 4'sd4;
        do_reset(126);
        repeat (4) tick();
        for (int r = 0; r < 3; r++) begin
            cal_en = 1'b1; stim_in = 1'b1; repeat (10) tick();
            cal_en = 1'b0; stim_in = 1'b0; repeat (10) tick();
        end
        chk(int'(n_code) == 127, "R7 ceiling", int'(n_code), 127);

        // R7: downward saturation.
        s1_code = -4'sd4;
        do_reset(-127);
        repeat (4) tick();
        for (int r = 0; r < 3; r++) begin
            cal_en = 1'b1; stim_in = 1'b1; repeat (10) tick();
            cal_en = 1'b0; stim_in = 1'b0; repeat (10) tick();
        end
        chk(int'(n_code) == -128, "R7 floor", int'(n_code), -128);

        // R4: output clipping at the negative limit with the largest gain.
        s1_code = -4'sd8; s2_code = '0;
        do_reset(127);
        repeat (3) tick();
        for (int i = 0; i < 10; i++) begin
            s2_code = (i % 2 == 0) ? 4'sd7 : -4'sd8;
            tick();
        end
        chk(seen_sat, "R4 negative clip observed", int'(seen_sat), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule